// File: doc/BRIEF.md
# PCI Configuration Address Translator

This block sits between a host-bus decoder and a PCI host bridge. When the host touches the south-bridge configuration window, the block receives the window offset, the access size, a read or write strobe and the current contents of a map-configuration register. It turns these into a PCI type-0 configuration address that the bridge's bus engine can use directly.

The internal address is formed in two halves. The upper half comes from the low 16 bits of the map register, and the lower half comes from the low 16 bits of the offset. Within that address, a one-hot device-select field starting at bit 11 is reduced to a binary device number. Function and register numbers are taken straight from the low bits of the address.

One cycle after each strobe, the block reports exactly one outcome:
- an issued cycle, with the formatted address and a pulse that clears the bridge's received-abort status bits;
- an abort, when the mapping mode is unsupported or the size code is reserved;
- a select error, when no usable device-select bit is present.

Rejected reads supply an all-ones fill value sized to the access.

Top module: `pcx_cfg_xlate`

## Requirements
- R1: While reset is high and in the cycle after it, all outputs are zero.
- R2: Every cycle with `acc_rd` or `acc_wr` high produces `done` high exactly one clock later. No `done` appears without a strobe. When both strobes are high, the access is treated as a write (`cfg_write`=1).
- R3: If bit 16 of `map_cfg` is set, the result is `cfg_abort`=1 with `cfg_go`=0 and `cfg_addr`=0. The abort takes priority over a select error.
- R4: `rd_fill` depends on the outcome:
  - for a rejected read, all ones for the size: size code 0 (1 byte) gives 0x000000FF, code 1 (2 bytes) gives 0x0000FFFF, codes 2 and 3 give 0xFFFFFFFF;
  - for writes and issued reads, it is 0.
- R5: The device-select field is internal address bits [31:11]. The device number is the position of its lowest set bit minus 12, so address bit 17 gives device 5 and bit 31 gives device 19.
- R6: The function number is internal bits [10:8]. The register offset is internal bits [7:2], placed at `cfg_addr[7:2]`, with `cfg_addr[1:0]`=0.
- R7: An issued address has bit 31 = 1, bits [30:24] = 0, `bus_num` in [23:16], the device in [15:11] and the function in [10:8].
- R8: Internal bits [31:16] come from `map_cfg[15:0]`. Offset bits 16 and above have no effect on the result.
- R9: If the select field is all zero, or its lowest set bit is bit 11, the result is `idsel_err`=1 with `cfg_go`=0 and `cfg_addr`=0. Exactly one of `cfg_go`, `cfg_abort` and `idsel_err` is high with each `done`.
- R10: `clr_status` is high for one cycle together with each issued read or write, and low otherwise.
- R11: Size code 3 is reserved and produces `cfg_abort`=1. Codes 0, 1 and 2 (1, 2 and 4 bytes) are accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_rd | input | 1 | Read strobe, one cycle per access |
| acc_wr | input | 1 | Write strobe, one cycle per access |
| acc_size | input | 2 | Size code: 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = reserved |
| acc_ofs | input | 19 | Byte offset inside the configuration window |
| map_cfg | input | 32 | Map-configuration register contents |
| bus_num | input | 8 | Bus number placed in the output address |
| done | output | 1 | Result strobe, one cycle after the access |
| cfg_go | output | 1 | Configuration cycle issued |
| cfg_write | output | 1 | Issued or rejected access was a write |
| cfg_abort | output | 1 | Unsupported mode or reserved size |
| idsel_err | output | 1 | No usable device-select bit |
| cfg_addr | output | 32 | Formatted configuration address, zero unless issued |
| rd_fill | output | 32 | All-ones fill for a rejected read |
| clr_status | output | 1 | Pulse to clear received master/target abort status |

## Verification
Every result of this block appears on the first rising edge after the strobe, through a single register stage; there is no later effect. The bench drives each strobe on a falling edge and samples all outputs on the next falling edge. It then checks one edge later that the result and the status-clear pulse have dropped. Back-to-back strobes are checked the same way, each result one cycle behind its own access.

// File: rtl/pcx_pkg.sv
package pcx_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } size_code_e;

  function automatic logic [31:0] fill_for(input logic [1:0] sz);
    case (sz)
      SZ_BYTE: fill_for = 32'h0000_00FF;
      SZ_HALF: fill_for = 32'h0000_FFFF;
      default: fill_for = 32'hFFFF_FFFF;
    endcase
  endfunction
endpackage

// File: rtl/pcx_lowbit_enc.sv
module pcx_lowbit_enc #(
  parameter int W  = 21,
  parameter int IW = $clog2(W)
) (
  input  logic [W-1:0]  vec,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/pcx_decode.sv
module pcx_decode
  import pcx_pkg::*;
#(
  parameter int OFS_W     = 19,
  parameter int BUS_W     = 8,
  parameter int SEL_LSB   = 11,
  parameter int SLOT_BASE = 12,
  parameter int DEV_W     = 5
) (
  input  logic [OFS_W-1:0] ofs,
  input  logic [31:0]      map_cfg,
  input  logic [1:0]       size,
  input  logic [BUS_W-1:0] bus,
  output logic             unsup,
  output logic             sel_bad,
  output logic [31:0]      addr_out
);
  localparam int SEL_W = 32 - SEL_LSB;
  localparam int IW    = $clog2(SEL_W);
  localparam int SKIP  = SLOT_BASE - SEL_LSB;
  localparam int PAD_W = 31 - 16 - BUS_W;

  logic [31:0]      inner;
  logic             hit;
  logic [IW-1:0]    pos;
  logic [DEV_W-1:0] dev;

  assign inner = {map_cfg[15:0], ofs[15:0]};

  pcx_lowbit_enc #(.W(SEL_W), .IW(IW)) u_enc (
    .vec  (inner[31:SEL_LSB]),
    .found(hit),
    .idx  (pos)
  );

  assign unsup   = map_cfg[16] || (size == SZ_RSVD);
  assign sel_bad = !hit || (int'(pos) < SKIP);
  assign dev     = DEV_W'(int'(pos) - SKIP);

  generate
    if (PAD_W > 0) begin : g_pad
      assign addr_out = {1'b1, {PAD_W{1'b0}}, bus, dev, inner[10:8], inner[7:2], 2'b00};
    end else begin : g_nopad
      assign addr_out = {1'b1, bus[BUS_W-1:0], dev, inner[10:8], inner[7:2], 2'b00};
    end
  endgenerate
endmodule

// File: rtl/pcx_out_reg.sv
module pcx_out_reg
  import pcx_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        acc,
  input  logic        is_wr,
  input  logic [1:0]  size,
  input  logic        unsup,
  input  logic        sel_bad,
  input  logic [31:0] addr_in,
  output logic        done,
  output logic        go,
  output logic        wr_q,
  output logic        abort,
  output logic        sel_err,
  output logic [31:0] addr_q,
  output logic [31:0] fill_q,
  output logic        clr_q
);
  logic ok, rej_rd;
  assign ok     = !unsup && !sel_bad;
  assign rej_rd = !ok && !is_wr;

  always_ff @(posedge clk) begin
    if (rst) begin
      done    <= 1'b0;
      go      <= 1'b0;
      wr_q    <= 1'b0;
      abort   <= 1'b0;
      sel_err <= 1'b0;
      addr_q  <= '0;
      fill_q  <= '0;
      clr_q   <= 1'b0;
    end else begin
      done    <= acc;
      go      <= acc && ok;
      clr_q   <= acc && ok;
      wr_q    <= acc && is_wr;
      abort   <= acc && unsup;
      sel_err <= acc && !unsup && sel_bad;
      addr_q  <= (acc && ok) ? addr_in : '0;
      fill_q  <= (acc && rej_rd) ? fill_for(size) : '0;
    end
  end

  // R2: result one cycle after each strobe, none without one
  a_r2_done_follows: assert property (@(posedge clk) disable iff (rst) acc |=> done);
  a_r2_no_spurious:  assert property (@(posedge clk) disable iff (rst) !acc |=> !done);
  // R9: exactly one outcome per result
  a_r9_one_outcome:  assert property (@(posedge clk) disable iff (rst)
                       done |-> $countones({go, abort, sel_err}) == 1);
  // R10: status clear only with an issued address
  a_r10_clr_issue:   assert property (@(posedge clk) disable iff (rst)
                       clr_q |-> (go && addr_q[31]));
  // R7: enable bit only on issued cycles
  a_r7_enable_go:    assert property (@(posedge clk) disable iff (rst) addr_q[31] |-> go);
  // R4: writes never carry fill
  a_r4_write_nofill: assert property (@(posedge clk) disable iff (rst)
                       (done && wr_q) |-> fill_q == 32'h0);
endmodule

// File: rtl/pcx_cfg_xlate.sv
module pcx_cfg_xlate
  import pcx_pkg::*;
#(
  parameter int OFS_W     = 19,
  parameter int BUS_W     = 8,
  parameter int SEL_LSB   = 11,
  parameter int SLOT_BASE = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             acc_rd,
  input  logic             acc_wr,
  input  logic [1:0]       acc_size,
  input  logic [OFS_W-1:0] acc_ofs,
  input  logic [31:0]      map_cfg,
  input  logic [BUS_W-1:0] bus_num,
  output logic             done,
  output logic             cfg_go,
  output logic             cfg_write,
  output logic             cfg_abort,
  output logic             idsel_err,
  output logic [31:0]      cfg_addr,
  output logic [31:0]      rd_fill,
  output logic             clr_status
);
  localparam int DEV_W = 5;

  logic        unsup, sel_bad;
  logic [31:0] addr_c;

  pcx_decode #(
    .OFS_W(OFS_W), .BUS_W(BUS_W), .SEL_LSB(SEL_LSB),
    .SLOT_BASE(SLOT_BASE), .DEV_W(DEV_W)
  ) u_dec (
    .ofs     (acc_ofs),
    .map_cfg (map_cfg),
    .size    (acc_size),
    .bus     (bus_num),
    .unsup   (unsup),
    .sel_bad (sel_bad),
    .addr_out(addr_c)
  );

  pcx_out_reg u_out (
    .clk    (clk),
    .rst    (rst),
    .acc    (acc_rd || acc_wr),
    .is_wr  (acc_wr),
    .size   (acc_size),
    .unsup  (unsup),
    .sel_bad(sel_bad),
    .addr_in(addr_c),
    .done   (done),
    .go     (cfg_go),
    .wr_q   (cfg_write),
    .abort  (cfg_abort),
    .sel_err(idsel_err),
    .addr_q (cfg_addr),
    .fill_q (rd_fill),
    .clr_q  (clr_status)
  );
endmodule

// File: tb/pcx_cfg_xlate_test.sv
module pcx_cfg_xlate_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        acc_rd = 1'b0, acc_wr = 1'b0;
  logic [1:0]  acc_size = 2'd0;
  logic [18:0] acc_ofs = '0;
  logic [31:0] map_cfg = '0;
  logic [7:0]  bus_num = '0;
  logic        done, cfg_go, cfg_write, cfg_abort, idsel_err, clr_status;
  logic [31:0] cfg_addr, rd_fill;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  pcx_cfg_xlate uut (
    .clk(clk), .rst(rst), .acc_rd(acc_rd), .acc_wr(acc_wr), .acc_size(acc_size),
    .acc_ofs(acc_ofs), .map_cfg(map_cfg), .bus_num(bus_num), .done(done),
    .cfg_go(cfg_go), .cfg_write(cfg_write), .cfg_abort(cfg_abort),
    .idsel_err(idsel_err), .cfg_addr(cfg_addr), .rd_fill(rd_fill),
    .clr_status(clr_status)
  );

  // stimulus: rd wr size ofs map bus | expected: go wr abort err addr fill
  localparam int NV = 12;
  localparam logic [130:0] VEC [NV] = '{
    {1'b1,1'b0,2'd2,19'h00010,32'h0000_0002,8'h03, 1'b1,1'b0,1'b0,1'b0,32'h8003_2810,32'h0},        // R5 bit17->dev5
    {1'b0,1'b1,2'd0,19'h00523,32'h0000_0001,8'h01, 1'b1,1'b1,1'b0,1'b0,32'h8001_2520,32'h0},        // R6 fn5 reg 0x20
    {1'b1,1'b0,2'd1,19'h00104,32'h0000_8000,8'hFF, 1'b1,1'b0,1'b0,1'b0,32'h80FF_9904,32'h0},        // R5 dev19 R7 bus
    {1'b1,1'b0,2'd2,19'h037FC,32'h0000_0004,8'h00, 1'b1,1'b0,1'b0,1'b0,32'h8000_07FC,32'h0},        // R5 bit12->dev0 R6
    {1'b1,1'b0,2'd2,19'h70008,32'h0000_0100,8'h00, 1'b1,1'b0,1'b0,1'b0,32'h8000_6008,32'h0},        // R8 high ofs ignored
    {1'b1,1'b0,2'd0,19'h00010,32'h0001_0002,8'h00, 1'b0,1'b0,1'b1,1'b0,32'h0,32'h0000_00FF},        // R3 R4 byte fill
    {1'b1,1'b0,2'd1,19'h00010,32'h0001_0000,8'h00, 1'b0,1'b0,1'b1,1'b0,32'h0,32'h0000_FFFF},        // R3 R4 half fill
    {1'b1,1'b0,2'd2,19'h00010,32'h0000_0000,8'h00, 1'b0,1'b0,1'b0,1'b1,32'h0,32'hFFFF_FFFF},        // R9 zero select
    {1'b1,1'b0,2'd2,19'h00810,32'h0000_0000,8'h00, 1'b0,1'b0,1'b0,1'b1,32'h0,32'hFFFF_FFFF},        // R9 only bit 11
    {1'b0,1'b1,2'd2,19'h00010,32'h0001_0000,8'h00, 1'b0,1'b1,1'b1,1'b0,32'h0,32'h0},                // R3 priority, write
    {1'b1,1'b0,2'd3,19'h00010,32'h0000_0002,8'h00, 1'b0,1'b0,1'b1,1'b0,32'h0,32'hFFFF_FFFF},        // R11 reserved size
    {1'b1,1'b1,2'd2,19'h00010,32'h0000_0002,8'h00, 1'b1,1'b1,1'b0,1'b0,32'h8000_2810,32'h0}         // R2 both -> write
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [62:0] s);
    {acc_rd, acc_wr, acc_size, acc_ofs, map_cfg, bus_num} = s;
  endtask

  initial begin
    #100000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 done in reset", 32'(done), 32'h0);
    chk("R1 addr in reset", cfg_addr, 32'h0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 outputs after reset", {cfg_go, cfg_abort, idsel_err, clr_status, rd_fill[27:0]}, 32'h0);
    chk("R2 no done without strobe", 32'(done), 32'h0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VEC[i][130:68]);
      @(negedge clk);
      acc_rd = 1'b0; acc_wr = 1'b0;
      chk($sformatf("R2 done v%0d", i), 32'(done), 32'h1);
      chk($sformatf("R9 outcome v%0d", i), {28'h0, cfg_go, cfg_write, cfg_abort, idsel_err}, {28'h0, VEC[i][67:64]});
      chk($sformatf("R7 addr v%0d", i), cfg_addr, VEC[i][63:32]);
      chk($sformatf("R4 fill v%0d", i), rd_fill, VEC[i][31:0]);
      chk($sformatf("R10 clr v%0d", i), 32'(clr_status), 32'(VEC[i][67]));
      @(negedge clk);
      chk($sformatf("R10 clr drops v%0d", i), {30'h0, clr_status, done}, 32'h0);
    end

    // back-to-back: read then write on consecutive cycles
    @(negedge clk);
    drive({1'b1,1'b0,2'd2,19'h00010,32'h0000_0002,8'h00});
    @(negedge clk);
    chk("R2 back-to-back first", {done, cfg_go, cfg_write, clr_status}, 4'b1101);
    drive({1'b0,1'b1,2'd2,19'h00010,32'h0000_0008,8'h00});
    @(negedge clk);
    acc_rd = 1'b0; acc_wr = 1'b0;
    chk("R2 back-to-back second", {done, cfg_go, cfg_write, clr_status}, 4'b1111);
    chk("R5 bit19 -> dev7", cfg_addr, 32'h8000_3810);

    // reset mid-stream clears results
    drive({1'b1,1'b0,2'd2,19'h00010,32'h0000_0002,8'h00});
    rst = 1'b1;
    @(negedge clk);
    acc_rd = 1'b0;
    chk("R1 reset overrides access", {30'h0, done, clr_status}, 32'h0);
    rst = 1'b0;
    @(negedge clk);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule